// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Level Masking

This block gathers 43 level-sensitive interrupt requests: 36 from peripherals and 7 from software-owned pending bits. Each source has a fixed priority level from 1 to 7 and a fixed slot inside that level. A two-tier arbiter first picks the best source inside each level. It then picks the highest level that the CPU's 3-bit mask does not block. The winner is presented to the CPU as a registered request level and an 8-bit vector number.

The CPU takes the interrupt by pulsing an acknowledge. One cycle later the block answers with the vector of the source that is winning at that moment. If no presentable source remains, it returns a fixed spurious vector. Software raises and lowers its own seven requests through a single write port that carries set and clear fields in one word.

Top module: `prio_intc`

## Requirements
- R1: Source i (0..35 on `periph_irq_i[i]`, 36..42 on software bit i-36) is reported with vector number 64+i, so an issued interrupt vector always lies in 64..255.
- R2: Source i has priority level (i mod 7)+1.
- R3: A higher level always beats a lower one. Among pending sources of the same level, the one with the lower slot (slot = i div 7, equivalently the lower index) wins.
- R4: A level L is presented only if L is greater than `mask_i`. Level 7 is presented for every mask value. With nothing presentable, `irq_level_o` is 0 and `irq_vec_o` is 0.
- R5: `irq_level_o` and `irq_vec_o` are registered and reflect the request and mask inputs as sampled at the previous clock edge.
- R6: Requests are level-sensitive. A source that drops is no longer reported in the cycle after it drops.
- R7: A write with `wr_en_i` high sets software bit k when `wr_data_i[k]` is 1 and clears it when `wr_data_i[8+k]` is 1. When both are 1 in the same write, the bit ends up set. Other bits are unchanged.
- R8: When `ack_i` is high at a clock edge, `ack_valid_o` is high in the next cycle with `ack_vec_o` equal to the vector of the source winning at that edge, or 24 if none is presentable. Otherwise `ack_valid_o` is low.
- R9: After reset, all software bits are clear and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| periph_irq_i | input | 36 | Peripheral request lines, active high, level-sensitive |
| mask_i | input | 3 | CPU interrupt mask level |
| wr_en_i | input | 1 | Write strobe for the software request register |
| wr_data_i | input | 16 | Bits 6:0 set software requests, bits 14:8 clear them |
| ack_i | input | 1 | Acknowledge pulse from the CPU |
| irq_level_o | output | 3 | Presented request level, 0 when none |
| irq_vec_o | output | 8 | Vector of the presented request |
| ack_valid_o | output | 1 | Acknowledge response valid |
| ack_vec_o | output | 8 | Vector returned for the acknowledge |

## Verification
The bench drives every source alone under all eight mask values. A wrong level map, vector offset or mask comparison shows up as a wrong or missing level. Level 7 under mask 7 catches a design that masks the top level. Every pair of peripheral sources is swept with a rotating mask: reversed slot order or a level-over-slot mix-up picks the wrong vector. Further checks cover an acknowledge after the request has withdrawn, which must yield 24 and not a stale vector, and a same-cycle set and clear, which must leave the bit pending.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int LVL_W    = 3;
  localparam int N_LVL    = 7;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 64;
  localparam int SPUR_VEC = 24;
  localparam int NMI_LVL  = 7;

  function automatic logic [LVL_W-1:0] src_level(input int i);
    return LVL_W'((i % N_LVL) + 1);
  endfunction

  function automatic logic [VEC_W-1:0] src_vector(input int i);
    return VEC_W'(VEC_BASE + i);
  endfunction
endpackage

// File: rtl/intc_sw_regs.sv
module intc_sw_regs #(
  parameter int N_SW = 7
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [N_SW-1:0] set_i,
  input  logic [N_SW-1:0] clr_i,
  output logic [N_SW-1:0] pend_o
);
  logic [N_SW-1:0] pend_q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= '0;
    else if (wr_en_i) pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  assert_set_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((pend_q & $past(set_i)) == $past(set_i)));

  assert_clear_only_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((pend_q & $past(clr_i) & ~$past(set_i)) == '0));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(pend_q));
endmodule

// File: rtl/intc_level_arb.sv
module intc_level_arb
  import prio_intc_pkg::*;
#(
  parameter int N_SRC = 43,
  parameter int LVL   = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);
  logic [N_SRC-1:0] grant;

  // lowest index in this level = lowest slot = highest sub-priority
  always_comb begin
    grant   = '0;
    valid_o = 1'b0;
    vec_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (!valid_o && req_i[i] && src_level(i) == LVL_W'(LVL)) begin
        grant[i] = 1'b1;
        valid_o  = 1'b1;
        vec_o    = src_vector(i);
      end
    end
  end

  assert_grant_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));

  assert_grant_in_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $countones(grant & req_i) == 1);
endmodule

// File: rtl/intc_level_sel.sv
module intc_level_sel
  import prio_intc_pkg::*;
(
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_LVL-1:0]           lvl_valid_i,
  input  logic [N_LVL-1:0][VEC_W-1:0] lvl_vec_i,
  input  logic [LVL_W-1:0]           mask_i,
  output logic                       win_valid_o,
  output logic [LVL_W-1:0]           win_level_o,
  output logic [VEC_W-1:0]           win_vec_o
);
  logic [N_LVL-1:0] allowed;

  // levels indexed 1..7 stored at 0..6
  always_comb begin
    for (int l = 0; l < N_LVL; l++)
      allowed[l] = lvl_valid_i[l] &&
                   ((LVL_W'(l + 1) > mask_i) || (l + 1 == NMI_LVL));
  end

  always_comb begin
    win_valid_o = 1'b0;
    win_level_o = '0;
    win_vec_o   = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (allowed[l]) begin
        win_valid_o = 1'b1;
        win_level_o = LVL_W'(l + 1);
        win_vec_o   = lvl_vec_i[l];
      end
    end
  end

  assert_nmi_unmasked_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_valid_i[NMI_LVL-1] |-> (win_level_o == LVL_W'(NMI_LVL)));

  assert_mask_respected_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_valid_o && win_level_o != LVL_W'(NMI_LVL)) |-> (win_level_o > mask_i));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int N_PERIPH = 36,
  parameter int N_SW     = 7,
  parameter int WR_W     = 16,
  parameter int CLR_LSB  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_PERIPH-1:0] periph_irq_i,
  input  logic [LVL_W-1:0]    mask_i,
  input  logic                wr_en_i,
  input  logic [WR_W-1:0]     wr_data_i,
  input  logic                ack_i,
  output logic [LVL_W-1:0]    irq_level_o,
  output logic [VEC_W-1:0]    irq_vec_o,
  output logic                ack_valid_o,
  output logic [VEC_W-1:0]    ack_vec_o
);
  localparam int N_SRC = N_PERIPH + N_SW;

  logic [N_SW-1:0]            sw_pend;
  logic [N_SRC-1:0]           req;
  logic [N_LVL-1:0]           lvl_valid;
  logic [N_LVL-1:0][VEC_W-1:0] lvl_vec;
  logic                       win_valid;
  logic [LVL_W-1:0]           win_level;
  logic [VEC_W-1:0]           win_vec;

  intc_sw_regs #(.N_SW(N_SW)) u_sw (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .set_i   (wr_data_i[N_SW-1:0]),
    .clr_i   (wr_data_i[CLR_LSB+N_SW-1:CLR_LSB]),
    .pend_o  (sw_pend)
  );

  assign req = {sw_pend, periph_irq_i};

  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    intc_level_arb #(.N_SRC(N_SRC), .LVL(l + 1)) u_arb (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req),
      .valid_o (lvl_valid[l]),
      .vec_o   (lvl_vec[l])
    );
  end

  intc_level_sel u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_valid_i (lvl_valid),
    .lvl_vec_i   (lvl_vec),
    .mask_i      (mask_i),
    .win_valid_o (win_valid),
    .win_level_o (win_level),
    .win_vec_o   (win_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_level_o <= '0;
      irq_vec_o   <= '0;
      ack_valid_o <= 1'b0;
      ack_vec_o   <= '0;
    end else begin
      irq_level_o <= win_valid ? win_level : '0;
      irq_vec_o   <= win_valid ? win_vec : '0;
      ack_valid_o <= ack_i;
      // live winner at the ack edge; withdrawn request yields spurious vector
      if (ack_i) ack_vec_o <= win_valid ? win_vec : VEC_W'(SPUR_VEC);
    end
  end

  assert_vec_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0) |-> (irq_vec_o >= VEC_W'(VEC_BASE)));

  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o == '0) |-> (irq_vec_o == '0));

  assert_reg_mask_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_o != '0 && irq_level_o != LVL_W'(NMI_LVL)) |-> (irq_level_o > $past(mask_i)));

  assert_ack_resp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> ack_valid_o);

  assert_ack_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> !ack_valid_o);

  assert_ack_vec_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (ack_vec_o == VEC_W'(SPUR_VEC) || ack_vec_o >= VEC_W'(VEC_BASE)));
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 36;
  localparam int NS = 7;
  localparam int NT = NP + NS;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [NP-1:0] periph = '0;
  logic [2:0]  mask = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        ack = 1'b0;
  logic [2:0]  irq_level;
  logic [7:0]  irq_vec;
  logic        ack_valid;
  logic [7:0]  ack_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prio_intc u0 (
    .clk_i(clk), .rst_ni(rst_ni), .periph_irq_i(periph), .mask_i(mask),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .ack_i(ack),
    .irq_level_o(irq_level), .irq_vec_o(irq_vec),
    .ack_valid_o(ack_valid), .ack_vec_o(ack_vec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference: highest allowed level wins, lowest index within level
  task automatic model(input logic [NT-1:0] r, input logic [2:0] m,
                       output int lvl, output int vec);
    lvl = 0; vec = 0;
    for (int i = 0; i < NT; i++) begin
      int l;
      l = (i % 7) + 1;
      if (r[i] && (l > int'(m) || l == 7) && l > lvl) begin
        lvl = l; vec = 64 + i;
      end
    end
  endtask

  task automatic sw_write(input logic [6:0] s, input logic [6:0] c);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {1'b0, c, 1'b0, s};
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic cmp(input logic [NT-1:0] r, input string tag);
    int el, ev;
    model(r, mask, el, ev);
    chk(int'(irq_level) == el, {tag, " level"}, int'(irq_level), el);
    chk(int'(irq_vec) == ev, {tag, " vector"}, int'(irq_vec), ev);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int el, ev;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(irq_level == 0, "R9 level", int'(irq_level), 0);
    chk(irq_vec == 0, "R9 vector", int'(irq_vec), 0);
    chk(ack_valid == 0, "R9 ack_valid", int'(ack_valid), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(irq_level == 0, "R9 idle after reset", int'(irq_level), 0);

    // R1 R2 R4: each peripheral alone, every mask
    for (int i = 0; i < NP; i++) begin
      for (int m = 0; m < 8; m++) begin
        periph = '0; periph[i] = 1'b1; mask = 3'(m);
        @(negedge clk); @(negedge clk);
        cmp({{NS{1'b0}}, periph}, "R1 R2 R4 single periph");
      end
    end
    periph = '0;

    // R7 R1 R2: each software source alone, every mask
    for (int k = 0; k < NS; k++) begin
      sw_write(7'(1 << k), 7'h00);
      for (int m = 0; m < 8; m++) begin
        logic [NT-1:0] r;
        mask = 3'(m);
        @(negedge clk); @(negedge clk);
        r = '0; r[NP+k] = 1'b1;
        cmp(r, "R7 R1 single software");
      end
      sw_write(7'h00, 7'(1 << k));
      mask = 3'd0;
      @(negedge clk); @(negedge clk);
      chk(irq_level == 0, "R7 clear", int'(irq_level), 0);
    end

    // R3 R4: all peripheral pairs with rotating mask
    for (int i = 0; i < NP; i++) begin
      for (int j = i + 1; j < NP; j++) begin
        periph = '0; periph[i] = 1'b1; periph[j] = 1'b1;
        mask = 3'((i + j) % 8);
        @(negedge clk); @(negedge clk);
        cmp({{NS{1'b0}}, periph}, "R3 R4 pair");
      end
    end
    periph = '0; mask = 3'd0;
    @(negedge clk); @(negedge clk);

    // R5: output follows one cycle after input change
    periph[3] = 1'b1;  // level 4
    @(negedge clk);
    chk(irq_level == 4, "R5 one-cycle update", int'(irq_level), 4);
    chk(irq_vec == 67, "R5 one-cycle vector", int'(irq_vec), 67);
    // R6: drop removes request next cycle
    periph[3] = 1'b0;
    @(negedge clk);
    chk(irq_level == 0, "R6 drop", int'(irq_level), 0);

    // R8: normal acknowledge
    periph[10] = 1'b1; periph[6] = 1'b1; // levels 4 and 7
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(ack_valid == 1, "R8 ack valid", int'(ack_valid), 1);
    chk(ack_vec == 70, "R8 ack vector", int'(ack_vec), 70);
    @(negedge clk);
    chk(ack_valid == 0, "R8 ack single cycle", int'(ack_valid), 0);

    // R8 R4: level 7 acked under mask 7, lower level blocked
    mask = 3'd7;
    @(negedge clk);
    chk(irq_level == 7, "R4 nmi under mask 7", int'(irq_level), 7);
    periph[6] = 1'b0;
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(ack_vec == 24, "R8 masked-only ack spurious", int'(ack_vec), 24);
    mask = 3'd0;

    // R6 R8: request withdrawn in the ack cycle gives spurious vector
    periph = '0; periph[20] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(irq_vec == 84, "R6 presented", int'(irq_vec), 84);
    periph[20] = 1'b0; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(ack_valid == 1 && ack_vec == 24, "R8 withdrawn spurious", int'(ack_vec), 24);

    // R7: set and clear together leaves bit set; other bits untouched
    sw_write(7'h05, 7'h00);           // sources 36 (lvl 2) and 38 (lvl 4)
    sw_write(7'h01, 7'h05);           // bit0 set+clear, bit2 cleared
    @(negedge clk);
    model({7'h01, {NP{1'b0}}}, mask, el, ev);
    chk(int'(irq_level) == el && int'(irq_vec) == ev, "R7 set wins", int'(irq_vec), ev);
    sw_write(7'h00, 7'h01);
    @(negedge clk);
    chk(irq_level == 0, "R7 final clear", int'(irq_level), 0);

    // R3: software vs peripheral same level, lower index wins
    periph[1] = 1'b1;                 // index 1, level 2
    sw_write(7'h01, 7'h00);           // index 36, level 2
    @(negedge clk);
    chk(irq_vec == 65, "R3 same level slot", int'(irq_vec), 65);
    periph = '0;
    @(negedge clk);
    chk(irq_vec == 100, "R3 software after peripheral drop", int'(irq_vec), 100);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule